// File: doc/BRIEF.md
# Rotate and Mask Unit

This block rotates a 32-bit source word left and then selects bits of the rotated word through a contiguous mask. The mask is given as a begin index and an end index, and bit positions are counted from the most significant bit: index 0 is the bit of weight 2^31. When begin exceeds end, the mask wraps around the top of the word.

A 6-bit operation code picks one of three modes. The first rotates by an immediate amount and ANDs the result with the mask. The second does the same rotation but inserts the rotated bits under the mask into an existing destination word. The third takes the rotate amount from a register operand and ANDs with the mask.

A record request adds a 4-bit condition field describing the result. The datapath is combinational. A parameter either places one output register after it or leaves the path unregistered. Register-file access and wider instruction decode are left to the surrounding pipeline.

Top module: `rm_unit`

## Requirements
- R1: With op_i = 21 the result is the source rotated left by sh_i, ANDed with the mask.
- R2: When mb_i <= me_i the mask holds exactly the big-endian indices mb_i through me_i inclusive, where index k is the bit of weight 2^(31-k).
- R3: When mb_i > me_i the mask holds the big-endian indices 0 through me_i together with mb_i through 31.
- R4: With op_i = 20 the result is (rotated AND mask) OR (dest_i AND NOT mask).
- R5: With op_i = 23 the rotate amount is amt_reg_i, and sh_i has no effect on the result.
- R6: A rotate amount of zero leaves the source unrotated.
- R7: For a recognised operation, crf_en_o equals rc_i. When it is set, crf_o[3] means negative, crf_o[2] means positive and crf_o[1] means zero, each judged on the signed result, and crf_o[0] copies so_i.
- R8: Any other op_i value gives op_ok_o = 0, result_o = 0, crf_en_o = 0 and crf_o = 0. Recognised codes give op_ok_o = 1.
- R9: With REG_OUT = 1 the outputs appear one clock after the inputs, and all outputs are zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Operation code: 20 insert, 21 immediate AND, 23 register AND |
| sh_i | input | 5 | Immediate rotate amount |
| mb_i | input | 5 | Mask begin index, big-endian |
| me_i | input | 5 | Mask end index, big-endian |
| rc_i | input | 1 | Record request |
| src_i | input | 32 | Word to rotate |
| dest_i | input | 32 | Old destination word for insert |
| amt_reg_i | input | 5 | Rotate amount from the register operand |
| so_i | input | 1 | Summary overflow copied into the condition field |
| result_o | output | 32 | Result word |
| crf_o | output | 4 | Condition field |
| crf_en_o | output | 1 | Condition field valid |
| op_ok_o | output | 1 | Operation code recognised |

## Verification
Random stimulus covers all three modes with arbitrary rotate amounts and mask bounds. Because the bounds are random, both the ordered and the wrapped mask appear, and any mix-up between the two mask rules shows up in the result.

Directed cases cover the remaining corners:
- Single-bit masks at both ends of the word separate an off-by-one in the range from a bit-order reversal.
- A full mask with zero rotation separates a correct rotator from one that shifts by the word width.
- In register mode, a sh_i field that disagrees with amt_reg_i shows which amount source is actually used.
- Zero, negative and positive results, with so_i set both ways, test each bit of the condition field.
- Unknown operation codes check that the outputs stay zeroed.

// File: rtl/rm_pkg.sv
package rm_pkg;
    parameter int DW = 32;
    localparam int SW = $clog2(DW);

    typedef enum logic [5:0] {
        OP_INSERT  = 6'd20,
        OP_IMM_AND = 6'd21,
        OP_REG_AND = 6'd23
    } rm_op_e;

    typedef struct packed {
        logic [DW-1:0] result;
        logic [3:0]    crf;
        logic          crf_en;
        logic          ok;
    } rm_out_t;
endpackage

// File: rtl/rm_rotl.sv
module rm_rotl #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl    = {data_i, data_i} << amt_i;
        data_o = dbl[2*W-1:W];
    end
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [SW-1:0] begin_i,
    input  logic [SW-1:0] end_i,
    output logic [W-1:0]  mask_o
);
    logic ordered;
    assign ordered = (begin_i <= end_i);

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [SW-1:0] BE_IDX = SW'(W - 1 - i);
        logic ge_b, le_e;
        assign ge_b = (BE_IDX >= begin_i);
        assign le_e = (BE_IDX <= end_i);
        assign mask_o[i] = ordered ? (ge_b & le_e) : (ge_b | le_e);
    end
endmodule

// File: rtl/rm_cond.sv
module rm_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] value_i,
    input  logic         so_i,
    output logic [3:0]   crf_o
);
    logic zero, neg;

    always_comb begin
        zero  = (value_i == '0);
        neg   = value_i[W-1];
        crf_o = {neg, ~neg & ~zero, zero, so_i};
    end
endmodule

// File: rtl/rm_unit.sv
module rm_unit #(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [5:0]             op_i,
    input  logic [rm_pkg::SW-1:0]  sh_i,
    input  logic [rm_pkg::SW-1:0]  mb_i,
    input  logic [rm_pkg::SW-1:0]  me_i,
    input  logic                   rc_i,
    input  logic [rm_pkg::DW-1:0]  src_i,
    input  logic [rm_pkg::DW-1:0]  dest_i,
    input  logic [rm_pkg::SW-1:0]  amt_reg_i,
    input  logic                   so_i,
    output logic [rm_pkg::DW-1:0]  result_o,
    output logic [3:0]             crf_o,
    output logic                   crf_en_o,
    output logic                   op_ok_o
);
    import rm_pkg::*;

    logic [SW-1:0] amt;
    logic [DW-1:0] rotated, mask, merged;
    logic [3:0]    crf_raw;
    logic          is_ins, is_imm, is_reg;
    rm_out_t       out_d, out_q;

    always_comb begin
        is_ins = (op_i == OP_INSERT);
        is_imm = (op_i == OP_IMM_AND);
        is_reg = (op_i == OP_REG_AND);
        amt    = is_reg ? amt_reg_i : sh_i;
    end

    rm_rotl #(.W(DW), .SW(SW)) u_rot (
        .data_i (src_i),
        .amt_i  (amt),
        .data_o (rotated)
    );

    rm_mask_gen #(.W(DW), .SW(SW)) u_mask (
        .begin_i (mb_i),
        .end_i   (me_i),
        .mask_o  (mask)
    );

    always_comb begin
        if (is_ins) merged = (rotated & mask) | (dest_i & ~mask);
        else        merged = rotated & mask;
    end

    rm_cond #(.W(DW)) u_cond (
        .value_i (merged),
        .so_i    (so_i),
        .crf_o   (crf_raw)
    );

    always_comb begin
        out_d = '0;
        if (is_ins | is_imm | is_reg) begin
            out_d.ok     = 1'b1;
            out_d.result = merged;
            out_d.crf_en = rc_i;
            out_d.crf    = rc_i ? crf_raw : 4'b0;
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign result_o = out_q.result;
    assign crf_o    = out_q.crf;
    assign crf_en_o = out_q.crf_en;
    assign op_ok_o  = out_q.ok;
endmodule

// File: rtl/rm_unit_chk.sv
module rm_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [5:0]             op_i,
    input logic [rm_pkg::SW-1:0]  sh_i,
    input logic [rm_pkg::SW-1:0]  mb_i,
    input logic [rm_pkg::SW-1:0]  me_i,
    input logic                   rc_i,
    input logic [rm_pkg::DW-1:0]  src_i,
    input logic [rm_pkg::DW-1:0]  dest_i,
    input logic [rm_pkg::SW-1:0]  amt_reg_i,
    input logic                   so_i,
    input logic [rm_pkg::DW-1:0]  result_o,
    input logic [3:0]             crf_o,
    input logic                   crf_en_o,
    input logic                   op_ok_o
);
    logic [5:0]            v_op;
    logic [rm_pkg::SW-1:0] v_sh, v_mb, v_me;
    logic                  v_rc, v_so;
    logic [rm_pkg::DW-1:0] v_src, v_dest;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_op <= '0; v_sh <= '0; v_mb <= '0; v_me <= '0;
                v_rc <= 1'b0; v_so <= 1'b0; v_src <= '0; v_dest <= '0;
            end else begin
                v_op <= op_i; v_sh <= sh_i; v_mb <= mb_i; v_me <= me_i;
                v_rc <= rc_i; v_so <= so_i; v_src <= src_i; v_dest <= dest_i;
            end
        end
    end else begin : g_now
        assign v_op = op_i;   assign v_sh = sh_i;   assign v_mb = mb_i;
        assign v_me = me_i;   assign v_rc = rc_i;   assign v_so = so_i;
        assign v_src = src_i; assign v_dest = dest_i;
    end

    logic known;
    assign known = (v_op == 6'd20) || (v_op == 6'd21) || (v_op == 6'd23);

    // R8
    unknown_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (result_o == '0 && !op_ok_o && !crf_en_o && crf_o == 4'b0));

    // R7
    record_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        known |-> (crf_en_o == v_rc && op_ok_o));

    // R7
    record_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crf_en_o |-> ($onehot(crf_o[3:1]) && crf_o[1] == (result_o == '0)
                      && crf_o[3] == result_o[rm_pkg::DW-1] && crf_o[0] == v_so));

    // R6
    zero_rot_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_op == 6'd21 && v_sh == '0 && v_mb == '0 && v_me == '1) |-> result_o == v_src);

    // R4
    insert_same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_op == 6'd20 && v_sh == '0 && v_src == v_dest) |-> result_o == v_src);
endmodule

bind rm_unit rm_unit_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_rm_unit.sv
module sim_rm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_i = '0;
    logic [4:0]  sh_i = '0, mb_i = '0, me_i = '0, amt_reg_i = '0;
    logic        rc_i = 1'b0, so_i = 1'b0;
    logic [31:0] src_i = '0, dest_i = '0;
    logic [31:0] result_o;
    logic [3:0]  crf_o;
    logic        crf_en_o, op_ok_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rm_unit #(.REG_OUT(1'b1)) u0 (.*);

    function automatic logic [31:0] ref_mask(input logic [4:0] b, input logic [4:0] e);
        logic [31:0] m = '0;
        for (int k = 0; k < 32; k++) begin
            bit in = (b <= e) ? (k >= b && k <= e) : (k <= e || k >= b);
            if (in) m = m | (32'h8000_0000 >> k);
        end
        return m;
    endfunction

    function automatic logic [31:0] ref_rot(input logic [31:0] d, input logic [4:0] n);
        logic [31:0] x = d;
        for (int k = 0; k < n; k++) x = {x[30:0], x[31]};
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [5:0] op, input logic [4:0] sh,
                         input logic [4:0] mb, input logic [4:0] me, input logic rc,
                         input logic [31:0] src, input logic [31:0] dst,
                         input logic [4:0] ra, input logic so);
        logic [31:0] rot, m, res;
        logic [3:0]  cf;
        bit          ok;
        @(negedge clk);
        op_i = op; sh_i = sh; mb_i = mb; me_i = me; rc_i = rc;
        src_i = src; dest_i = dst; amt_reg_i = ra; so_i = so;
        ok  = (op == 6'd20 || op == 6'd21 || op == 6'd23);
        rot = ref_rot(src, (op == 6'd23) ? ra : sh);
        m   = ref_mask(mb, me);
        res = (op == 6'd20) ? ((rot & m) | (dst & ~m)) : (rot & m);
        if (!ok) res = '0;
        cf = (ok && rc) ? {res[31], !res[31] && res != 0, res == 0, so} : 4'b0;
        @(posedge clk); #1;
        chk({req, " result"}, result_o, res);
        chk({req, " crf"}, {28'b0, crf_o}, {28'b0, cf});
        chk({req, " flags"}, {30'b0, crf_en_o, op_ok_o}, {30'b0, ok && rc, ok});
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        op_i = 6'd21; src_i = 32'hFFFF_FFFF; mb_i = 0; me_i = 31; rc_i = 1;
        repeat (3) @(posedge clk); #1;
        // R9: reset holds outputs at zero
        chk("R9 reset", {result_o[31:0]}, 32'h0);
        chk("R9 reset flags", {26'b0, crf_o, crf_en_o, op_ok_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 single bits at the ends, R1 mode
        apply("R2 msb only", 6'd21, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
        apply("R2 lsb only", 6'd21, 0, 31, 31, 0, 32'hFFFF_FFFF, 0, 0, 0);
        apply("R2 mid range", 6'd21, 4, 8, 23, 0, 32'h1234_5678, 0, 0, 0);
        // R3 wrapped masks
        apply("R3 wrap", 6'd21, 0, 28, 3, 0, 32'hFFFF_FFFF, 0, 0, 0);
        apply("R3 full wrap", 6'd21, 0, 1, 0, 0, 32'hA5A5_A5A5, 0, 0, 0);
        // R6 zero rotation with full mask
        apply("R6 zero rot", 6'd21, 0, 0, 31, 0, 32'hDEAD_BEEF, 0, 0, 0);
        apply("R1 rot 31", 6'd21, 31, 0, 31, 0, 32'h8000_0001, 0, 0, 0);
        // R4 insert
        apply("R4 insert", 6'd20, 8, 16, 23, 0, 32'h0000_00AB, 32'h1111_1111, 0, 0);
        apply("R4 insert wrap", 6'd20, 16, 24, 7, 1, 32'hCAFE_F00D, 32'h0F0F_0F0F, 0, 1);
        // R5 register amount, sh_i disagrees
        apply("R5 reg amt", 6'd23, 7, 0, 31, 0, 32'h0000_0001, 0, 12, 0);
        apply("R5 reg zero", 6'd23, 9, 0, 31, 0, 32'h1357_9BDF, 0, 0, 0);
        // R7 condition field cases
        apply("R7 zero", 6'd21, 0, 0, 31, 1, 32'h0, 0, 0, 1);
        apply("R7 neg", 6'd21, 0, 0, 31, 1, 32'h8000_0000, 0, 0, 0);
        apply("R7 pos", 6'd21, 0, 0, 31, 1, 32'h0000_0010, 0, 0, 1);
        // R8 unknown codes
        apply("R8 op22", 6'd22, 3, 0, 31, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 1);
        apply("R8 op0", 6'd0, 0, 0, 31, 1, 32'h1, 0, 0, 1);

        for (int n = 0; n < 400; n++) begin
            logic [5:0] op;
            logic [2:0] sel = 3'($urandom_range(0, 4));
            op = (sel == 0) ? 6'd20 : (sel == 1) ? 6'd21 : (sel == 2) ? 6'd23
               : (sel == 3) ? 6'd20 : 6'($urandom);
            apply("R1 R3 R4 R5 R7 random", op, 5'($urandom), 5'($urandom), 5'($urandom),
                  1'($urandom), $urandom, $urandom, 5'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule